// File: doc/BRIEF.md
# Sample Demultiplexer and Data-Clock Generator

This block sits between a converter core and a source-synchronous output port. It accepts one sample word and its out-of-range flag on each sampling-clock cycle and formats them for an output port with two buses. In non-demux mode only the primary bus is used, and it carries a new sample every cycle. In demux mode consecutive valid samples are grouped into pairs. The earlier sample of each pair goes on the delayed bus and the later sample goes on the primary bus. Both buses update together once every two cycles.

The block also generates a data clock that changes on both of its edges. In demux mode its period is four sampling cycles, and a phase control can move it by one cycle so that its edges fall in the middle of the data window. In non-demux mode its period is two cycles. A test mode replaces the samples with a looping four-word pattern. A sync pulse, or any change of mode, restarts the data-clock divider, the pairing and the pattern. This lets several instances be lined up in phase. An output enable stands in for the high-impedance state of the delayed bus.

Top module: `smp_demux_dclk`

## Requirements
- R1: While reset is asserted, every data and flag output, the delayed-bus enable and the data clock are 0.
- R2: In non-demux mode (`demux_en`=0), the primary bus shows the sample and flag from the previous cycle if that cycle had `in_valid`=1, and otherwise holds its value. The delayed bus reads 0 with its enable low.
- R3: In demux mode with every sample valid, the delayed bus carries the earlier sample of a pair and the primary bus the later one. Both change in the same cycle, once every two cycles, and the delayed-bus enable is high.
- R4: In demux mode, pairs are formed only from valid samples. Invalid cycles are skipped, and the buses hold their value until the next pair is launched on a two-cycle slot.
- R5: In demux mode with `phase_sel`=0, the data clock has a period of 4 cycles and changes in the same cycles as the data buses.
- R6: In demux mode with `phase_sel`=1, every data-clock edge comes one cycle later than with `phase_sel`=0, so it falls mid-data.
- R7: In non-demux mode the data clock toggles every cycle, and `phase_sel` does not affect it.
- R8: With `test_en`=1, inputs are ignored. The data outputs cycle through pattern words 0,1,2,3 in order, with flags 0,1,0,1. In demux mode the delayed bus takes the even word and the primary bus the odd word.
- R9: A `dclk_sync` pulse, or a change of `demux_en`, `phase_sel` or `test_en`, starts a restart cycle. The data clock goes low, the sample in that cycle is dropped, and the next valid sample becomes the first (delayed-bus) sample of a new pair.
- R10: Each out-of-range flag leaves the block on the same bus and in the same cycle as its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_data | input | DATA_W | Sample word |
| in_ovr | input | 1 | Out-of-range flag of the sample |
| demux_en | input | 1 | 1 = two-bus demux mode, 0 = single bus |
| phase_sel | input | 1 | 1 = data clock shifted by a quarter period (demux only) |
| test_en | input | 1 | Replace samples with the test pattern |
| dclk_sync | input | 1 | Realign pulse for the data-clock divider |
| pri_data | output | DATA_W | Primary bus data (later sample) |
| pri_ovr | output | 1 | Primary bus out-of-range flag |
| dly_data | output | DATA_W | Delayed bus data (earlier sample) |
| dly_ovr | output | 1 | Delayed bus out-of-range flag |
| dly_oe | output | 1 | Delayed bus enable |
| dclk | output | 1 | Data clock |

## Verification
The hardest case to reach is a pair that completes on a non-launch slot, because it must wait one cycle in the pending store while invalid cycles shift the pair boundary against the two-cycle slots. Random valid patterns in demux mode reach this case, and so do sync pulses and mode flips that land at arbitrary offsets within a pair. Every cycle is checked against a bench model of pairing, slots and pattern index.

// File: rtl/smp_demux_pkg.sv
package smp_demux_pkg;
  localparam int SLOT_W = 2;

  typedef struct packed {
    logic demux;
    logic ph90;
    logic tpat;
  } mode_t;

  // Target level of the quarter-rate data clock for a given slot.
  function automatic logic dclk_target(input logic [SLOT_W-1:0] slot,
                                       input logic ph90, input logic cur);
    logic t;
    t = cur;
    if (!ph90) begin
      if (slot == 2'd1) t = 1'b1;
      else if (slot == 2'd3) t = 1'b0;
    end else begin
      if (slot == 2'd2) t = 1'b1;
      else if (slot == 2'd0) t = 1'b0;
    end
    return t;
  endfunction
endpackage

// File: rtl/smp_demux_ctrl.sv
module smp_demux_ctrl
  import smp_demux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              demux_en,
  input  logic              phase_sel,
  input  logic              test_en,
  input  logic              dclk_sync,
  output logic              restart,
  output logic              launch,
  output logic              dclk
);
  mode_t             mode_d, mode_q;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              dclk_q, dclk_d;

  assign mode_d  = '{demux: demux_en, ph90: phase_sel, tpat: test_en};
  assign restart = dclk_sync | (mode_d != mode_q);
  assign launch  = demux_en & slot_q[0] & ~restart;
  assign dclk    = dclk_q;

  always_comb begin
    slot_d = slot_q + 1'b1;
    dclk_d = ~dclk_q;
    if (demux_en) dclk_d = dclk_target(slot_q, phase_sel, dclk_q);
    if (restart) begin
      slot_d = '0;
      dclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      slot_q <= '0;
      dclk_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      slot_q <= slot_d;
      dclk_q <= dclk_d;
    end
  end
endmodule

// File: rtl/smp_demux_pair.sv
module smp_demux_pair #(
  parameter int WW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          launch,
  input  logic          demux_en,
  input  logic          in_valid,
  input  logic [WW-1:0] in_word,
  output logic          upd,
  output logic [WW-1:0] early_word,
  output logic [WW-1:0] late_word
);
  logic          have_q, have_d;
  logic          pend_q, pend_d;
  logic [WW-1:0] first_q, first_d;
  logic [WW-1:0] pe_q, pe_d, pl_q, pl_d;
  logic          complete;

  assign complete   = demux_en & ~restart & in_valid & have_q;
  assign upd        = launch & (complete | pend_q);
  assign early_word = complete ? first_q : pe_q;
  assign late_word  = complete ? in_word : pl_q;

  always_comb begin
    have_d  = have_q;
    pend_d  = pend_q;
    first_d = first_q;
    pe_d    = pe_q;
    pl_d    = pl_q;
    if (restart || !demux_en) begin
      have_d = 1'b0;
      pend_d = 1'b0;
    end else begin
      if (in_valid) begin
        if (!have_q) begin
          first_d = in_word;
          have_d  = 1'b1;
        end else begin
          have_d = 1'b0;
        end
      end
      if (launch) begin
        pend_d = 1'b0;
      end else if (complete) begin
        pend_d = 1'b1;
        pe_d   = first_q;
        pl_d   = in_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      pend_q  <= 1'b0;
      first_q <= '0;
      pe_q    <= '0;
      pl_q    <= '0;
    end else begin
      have_q  <= have_d;
      pend_q  <= pend_d;
      first_q <= first_d;
      pe_q    <= pe_d;
      pl_q    <= pl_d;
    end
  end
endmodule

// File: rtl/smp_demux_tpgen.sv
module smp_demux_tpgen #(
  parameter int               W      = 12,
  parameter int               TP_LEN = 4,
  parameter logic [TP_LEN*W-1:0] TP_WORDS = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step1,
  input  logic         step2,
  output logic [W:0]   word_a,
  output logic [W:0]   word_b
);
  localparam int IDX_W = $clog2(TP_LEN);

  logic [W-1:0]     tbl [TP_LEN];
  logic [IDX_W-1:0] idx_q, idx_d, idx_b;

  for (genvar k = 0; k < TP_LEN; k++) begin : g_tbl
    assign tbl[k] = TP_WORDS[k*W +: W];
  end

  assign idx_b  = idx_q + 1'b1;
  assign word_a = {idx_q[0], tbl[idx_q]};
  assign word_b = {idx_b[0], tbl[idx_b]};

  always_comb begin
    idx_d = idx_q;
    if (restart)    idx_d = '0;
    else if (step2) idx_d = idx_q + 2'd2;
    else if (step1) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/smp_demux_dclk.sv
module smp_demux_dclk #(
  parameter int                  DATA_W   = 12,
  parameter int                  TP_LEN   = 4,
  parameter logic [TP_LEN*DATA_W-1:0] TP_WORDS = {12'hA5C, 12'h3F0, 12'hFFF, 12'h000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_ovr,
  input  logic              demux_en,
  input  logic              phase_sel,
  input  logic              test_en,
  input  logic              dclk_sync,
  output logic [DATA_W-1:0] pri_data,
  output logic              pri_ovr,
  output logic [DATA_W-1:0] dly_data,
  output logic              dly_ovr,
  output logic              dly_oe,
  output logic              dclk
);
  localparam int WW = DATA_W + 1;

  logic          restart, launch, upd;
  logic [WW-1:0] early_w, late_w, tp_a, tp_b, in_w;
  logic [WW-1:0] pri_q, pri_d, dly_q, dly_d;
  logic          oe_q;

  assign in_w = {in_ovr, in_data};

  smp_demux_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .demux_en(demux_en), .phase_sel(phase_sel),
    .test_en(test_en), .dclk_sync(dclk_sync), .restart(restart),
    .launch(launch), .dclk(dclk)
  );

  smp_demux_pair #(.WW(WW)) u_pair (
    .clk(clk), .rst_n(rst_n), .restart(restart), .launch(launch),
    .demux_en(demux_en), .in_valid(in_valid), .in_word(in_w), .upd(upd),
    .early_word(early_w), .late_word(late_w)
  );

  smp_demux_tpgen #(.W(DATA_W), .TP_LEN(TP_LEN), .TP_WORDS(TP_WORDS)) u_tp (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .step1(~restart & ~demux_en & test_en),
    .step2(launch & test_en),
    .word_a(tp_a), .word_b(tp_b)
  );

  always_comb begin
    pri_d = pri_q;
    dly_d = dly_q;
    if (!restart) begin
      if (!demux_en) begin
        if (test_en)       pri_d = tp_a;
        else if (in_valid) pri_d = in_w;
      end else if (test_en) begin
        if (launch) begin
          dly_d = tp_a;
          pri_d = tp_b;
        end
      end else if (upd) begin
        dly_d = early_w;
        pri_d = late_w;
      end
    end
    if (!demux_en) dly_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      dly_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      pri_q <= pri_d;
      dly_q <= dly_d;
      oe_q  <= demux_en;
    end
  end

  assign {pri_ovr, pri_data} = pri_q;
  assign {dly_ovr, dly_data} = dly_q;
  assign dly_oe              = oe_q;
endmodule

// File: rtl/smp_demux_chk.sv
module smp_demux_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         demux_en,
  input logic         restart,
  input logic         dclk,
  input logic         dly_oe,
  input logic [W-1:0] dly_data,
  input logic         dly_ovr,
  input logic [W-1:0] pri_data,
  input logic         pri_ovr
);
  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (pri_data == '0 && !pri_ovr && dly_data == '0
                                && !dly_ovr && !dly_oe && !dclk)
        else $error("reset state violated");
    end
  end

  // R9: data clock low after a restart cycle
  a_r9_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !dclk);

  // R2: disabled delayed bus reads zero
  a_r2_dly_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dly_oe |-> (dly_data == '0 && !dly_ovr));

  // R7: data clock toggles every cycle in non-demux mode
  a_r7_nd_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!demux_en && !restart) |=> dclk != $past(dclk));

  // R5: no two consecutive data-clock changes in demux mode
  a_r5_dmx_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_oe && demux_en && !restart && dclk != $past(dclk)) |=> dclk == $past(dclk));
endmodule

bind smp_demux_dclk smp_demux_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .demux_en(demux_en), .restart(restart),
  .dclk(dclk), .dly_oe(dly_oe), .dly_data(dly_data), .dly_ovr(dly_ovr),
  .pri_data(pri_data), .pri_ovr(pri_ovr)
);

// File: tb/sim_smp_demux_dclk.sv
module sim_smp_demux_dclk;
  localparam int W = 12;
  localparam logic [4*W-1:0] TPW = {12'h5A3, 12'hC0F, 12'h1E7, 12'h842};

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ovr, demux_en, phase_sel, test_en, dclk_sync;
  logic [W-1:0] in_data, pri_data, dly_data;
  logic pri_ovr, dly_ovr, dly_oe, dclk;

  int n_chk = 0, n_fail = 0;
  string tag = "R2";

  always #2.5 clk = ~clk;

  smp_demux_dclk #(.DATA_W(W), .TP_LEN(4), .TP_WORDS(TPW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ovr(in_ovr), .demux_en(demux_en), .phase_sel(phase_sel),
    .test_en(test_en), .dclk_sync(dclk_sync), .pri_data(pri_data),
    .pri_ovr(pri_ovr), .dly_data(dly_data), .dly_ovr(dly_ovr),
    .dly_oe(dly_oe), .dclk(dclk)
  );

  // bench model state
  logic [2:0]  m_mode;
  logic [1:0]  m_slot, m_idx;
  logic        m_dclk, m_have, m_pend, m_oe;
  logic [W:0]  m_first, m_pe, m_pl, m_pri, m_dly;

  function automatic logic [W:0] tpw(input logic [1:0] k);
    return {k[0], TPW[k*W +: W]};
  endfunction

  task automatic model_reset();
    m_mode = '0; m_slot = '0; m_idx = '0; m_dclk = 0; m_have = 0;
    m_pend = 0; m_oe = 0; m_first = '0; m_pe = '0; m_pl = '0;
    m_pri = '0; m_dly = '0;
  endtask

  task automatic model_step();
    logic rs, lnch, cmp;
    logic [W:0] w;
    w    = {in_ovr, in_data};
    rs   = dclk_sync || ({demux_en, phase_sel, test_en} != m_mode);
    lnch = demux_en && m_slot[0] && !rs;
    cmp  = demux_en && !rs && in_valid && m_have;
    m_oe = demux_en;
    if (rs) begin
      m_slot = 0; m_dclk = 0; m_idx = 0; m_have = 0; m_pend = 0;
    end else if (!demux_en) begin
      m_dclk = ~m_dclk;
      m_slot = m_slot + 1;
      m_have = 0; m_pend = 0;
      if (test_en) begin m_pri = tpw(m_idx); m_idx = m_idx + 1; end
      else if (in_valid) m_pri = w;
    end else begin
      if (!phase_sel) begin
        if (m_slot == 1) m_dclk = 1; else if (m_slot == 3) m_dclk = 0;
      end else begin
        if (m_slot == 2) m_dclk = 1; else if (m_slot == 0) m_dclk = 0;
      end
      if (test_en) begin
        if (lnch) begin
          m_dly = tpw(m_idx); m_pri = tpw(m_idx + 2'd1); m_idx = m_idx + 2;
        end
      end else if (lnch && cmp) begin
        m_dly = m_first; m_pri = w;
      end else if (lnch && m_pend) begin
        m_dly = m_pe; m_pri = m_pl;
      end
      if (lnch) m_pend = 0;
      else if (cmp) begin m_pend = 1; m_pe = m_first; m_pl = w; end
      if (in_valid) begin
        if (!m_have) begin m_first = w; m_have = 1; end
        else m_have = 0;
      end
      m_slot = m_slot + 1;
    end
    if (!demux_en) m_dly = '0;
    m_mode = {demux_en, phase_sel, test_en};
  endtask

  task automatic chk(input string r, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic compare();
    string dt;
    dt = (m_mode[2] ? (m_mode[1] ? "R6" : "R5") : "R7");
    if (tag == "R9") dt = "R9";
    chk(tag, {1'b0, pri_data}, {1'b0, m_pri[W-1:0]});
    chk(tag, {1'b0, dly_data}, {1'b0, m_dly[W-1:0]});
    chk(tag == "R8" ? "R8" : "R10", {{(W-1){1'b0}}, pri_ovr, dly_ovr},
        {{(W-1){1'b0}}, m_pri[W], m_dly[W]});
    chk(tag, {{W{1'b0}}, dly_oe}, {{W{1'b0}}, m_oe});
    chk(dt, {{W{1'b0}}, dclk}, {{W{1'b0}}, m_dclk});
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      model_step();
      compare();
    end
  endtask

  task automatic drive_rand(input int pct_valid);
    in_valid = (($urandom % 100) < pct_valid);
    in_data  = W'($urandom);
    in_ovr   = ($urandom % 4) == 0;
  endtask

  task automatic run_rand(input int n, input int pct);
    for (int i = 0; i < n; i++) begin
      drive_rand(pct);
      cyc(1);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1 - 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; in_valid = 0; in_data = '0; in_ovr = 0;
    demux_en = 0; phase_sel = 0; test_en = 0; dclk_sync = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", {1'b0, pri_data}, '0);
    chk("R1", {1'b0, dly_data}, '0);
    chk("R1", {{(W-2){1'b0}}, pri_ovr, dly_ovr, dly_oe}, '0);
    chk("R1", {{W{1'b0}}, dclk}, '0);
    rst_n = 1;

    // R2: non-demux, directed then random valid
    tag = "R2";
    in_valid = 1; in_data = 12'h123; in_ovr = 1; cyc(1);
    in_valid = 0; in_data = 12'hBAD; in_ovr = 0; cyc(2);
    run_rand(40, 70);
    phase_sel = 1; run_rand(20, 90);  // R7: phase ignored in non-demux
    phase_sel = 0;

    // R3: demux with every sample valid
    tag = "R3"; demux_en = 1;
    run_rand(40, 100);
    // R4: demux with gaps
    tag = "R4";
    run_rand(80, 55);
    // R6: quarter-period shifted clock
    tag = "R3"; phase_sel = 1;
    run_rand(40, 100);
    // R9: sync pulses at different offsets within a pair
    for (int k = 0; k < 6; k++) begin
      tag = "R9"; dclk_sync = 1; drive_rand(100); cyc(1);
      dclk_sync = 0; drive_rand(100); cyc(1);
      tag = "R3"; run_rand(k + 3, 100);
    end
    // R8: test pattern in both modes
    tag = "R8"; test_en = 1; run_rand(24, 50);
    demux_en = 0; run_rand(24, 50);
    test_en = 0;

    // R10: random mix with mode flips and sync pulses
    tag = "R10";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 60) == 0) demux_en  = ~demux_en;
      if (($urandom % 80) == 0) phase_sel = ~phase_sel;
      if (($urandom % 150) == 0) test_en  = ~test_en;
      dclk_sync = (($urandom % 70) == 0);
      drive_rand(($urandom % 2) ? 100 : 60);
      cyc(1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule